// File: doc/BRIEF.md
# Pairwise Reduction Stage With Set Boundaries

This block is one level of an integer adder tree. It takes a stream of operands, one per cycle at most, and joins each two consecutive valid operands into one partial sum. The sum passes through a pipelined adder of fixed latency `L`, which is modelled inside the block as a chain of registers. At full input rate the level emits one result every second cycle, so a chain of these levels divides the data rate by two at each step.

Operands belong to sets of any length. The producer marks the final operand of each set with `in_last`. A set of odd length closes cleanly: its final operand is added to zero instead of waiting for a partner. A last-of-set marker runs alongside the adder pipeline, so each result still shows whether it ends its set. Once a set has closed, the pairing state is empty again, and the first operand of the next set may arrive in the very next cycle.

The interface is a valid-qualified stream with no ready signal in either direction. The producer may leave idle cycles between operands whenever it likes, and the level holds its pairing state across them. Downstream must accept `out_valid` in every cycle in which it is high, because a result cannot be held back. The reset is synchronous and active high.

Top module: `pair_reduce_stage`

## Requirements
- R1: Two consecutive valid operands of one set, where the second is not last, give one result equal to their sum with `out_last` = 0.
- R2: The first operand of a pair waits in a holding register for any number of idle cycles, and the pairing status flips on every valid operand that is not last.
- R3: A last operand that arrives while the holding register is empty is added to zero and gives a result with `out_last` = 1.
- R4: A last operand that arrives while an operand is held is added to the held value and gives a result with `out_last` = 1.
- R5: A result appears on the outputs exactly `L` cycles after the cycle in which the operand that completed it was presented.
- R6: After a last operand the holding register counts as empty, so a set that starts in the next cycle pairs only its own operands.
- R7: `in_data` and `in_last` have no effect in cycles where `in_valid` is low.
- R8: `out_sum` is `W+1` bits wide and carries the full sum of two `W`-bit unsigned operands without loss.
- R9: Synchronous reset discards a held operand and clears the valid and last pipelines; `out_valid` and `out_last` are 0 in the cycle after reset.
- R10: `out_last` is high only together with `out_valid`, and results leave in the same order as their operands arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present in this cycle |
| in_data | input | W | Unsigned operand |
| in_last | input | 1 | Operand ends its set; used only with `in_valid` |
| out_valid | output | 1 | Result present in this cycle |
| out_sum | output | W+1 | Partial sum |
| out_last | output | 1 | Result ends its set |

## Verification
The assertions watch the pairing status on every cycle: it flips on each valid operand that is not last, it is empty after each last operand, it stays the same through idle cycles and reset clears it. They also check that `out_last` never appears without `out_valid`. The values of the sums, the exact `L`-cycle latency, the order of the results, and the zero fill for odd sets can only be shown by the bench. It compares every result with its own pairing model, over all set lengths up to nine, with no gaps, with regular gaps, with irregular gaps and with operands at their largest value. It also resets the block while an operand is held.

// File: rtl/pair_reduce_pkg.sv
package pair_reduce_pkg;

  typedef enum logic {
    HOLD_EMPTY = 1'b0,
    HOLD_FULL  = 1'b1
  } hold_state_e;

  function automatic int sum_width(input int w);
    return w + 1;
  endfunction

endpackage

// File: rtl/pr_pair_collect.sv
module pr_pair_collect
  import pair_reduce_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         launch,
  output logic         launch_last,
  output logic [W-1:0] opa,
  output logic [W-1:0] opb,
  output logic         hold_full
);

  hold_state_e  state_q;
  logic [W-1:0] hold_q;
  logic         have_pair;

  assign have_pair = (state_q == HOLD_FULL);

  // the operand that completes a pair, or an odd last item on its own
  assign launch      = in_valid && (have_pair || in_last);
  assign launch_last = launch && in_last;

  // 2-to-1 operand select: held value with new item, or new item with zero
  always_comb begin
    if (have_pair) begin
      opa = hold_q;
      opb = in_data;
    end else begin
      opa = in_data;
      opb = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HOLD_EMPTY;
      hold_q  <= '0;
    end else if (in_valid) begin
      if (have_pair || in_last) begin
        state_q <= HOLD_EMPTY;
      end else begin
        state_q <= HOLD_FULL;
        hold_q  <= in_data;
      end
    end
  end

  assign hold_full = have_pair;

endmodule

// File: rtl/pr_adder_pipe.sv
module pr_adder_pipe #(
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic          vld_o,
  output logic [W:0]    sum_o
);

  localparam int SW = W + 1;

  logic [SW-1:0] sum_q [L];
  logic [L-1:0]  vld_q;
  logic [SW-1:0] sum_in;

  assign sum_in = {1'b0, a} + {1'b0, b};

  for (genvar g = 0; g < L; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q[g] <= 1'b0;
          sum_q[g] <= '0;
        end else begin
          vld_q[g] <= go;
          sum_q[g] <= go ? sum_in : '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q[g] <= 1'b0;
          sum_q[g] <= '0;
        end else begin
          vld_q[g] <= vld_q[g-1];
          sum_q[g] <= sum_q[g-1];
        end
      end
    end
  end

  assign vld_o = vld_q[L-1];
  assign sum_o = sum_q[L-1];

endmodule

// File: rtl/pr_flag_delay.sv
module pr_flag_delay #(
  parameter int L = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_i,
  output logic flag_o
);

  logic [L-1:0] sr_q;

  if (L == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) sr_q <= '0;
      else     sr_q <= flag_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) sr_q <= '0;
      else     sr_q <= {sr_q[L-2:0], flag_i};
    end
  end

  assign flag_o = sr_q[L-1];

endmodule

// File: rtl/pair_reduce_stage.sv
module pair_reduce_stage #(
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  output logic [W:0]   out_sum,
  output logic         out_last
);

  logic         launch;
  logic         launch_last;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         hold_full;

  pr_pair_collect #(.W(W)) u_collect (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .launch      (launch),
    .launch_last (launch_last),
    .opa         (opa),
    .opb         (opb),
    .hold_full   (hold_full)
  );

  pr_adder_pipe #(.W(W), .L(L)) u_adder (
    .clk   (clk),
    .rst   (rst),
    .go    (launch),
    .a     (opa),
    .b     (opb),
    .vld_o (out_valid),
    .sum_o (out_sum)
  );

  pr_flag_delay #(.L(L)) u_last (
    .clk    (clk),
    .rst    (rst),
    .flag_i (launch_last),
    .flag_o (out_last)
  );

endmodule

// File: rtl/pair_reduce_stage_chk.sv
module pair_reduce_stage_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_last,
  input logic hold_full,
  input logic out_valid,
  input logic out_last
);

  p_hold_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_last) |=> (hold_full != $past(hold_full)))
    else $error("hold status did not flip on a non-last operand");

  p_last_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> !hold_full)
    else $error("hold status not empty after a last operand");

  p_idle_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(hold_full))
    else $error("hold status changed in an idle cycle");

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!hold_full && !out_valid && !out_last))
    else $error("state not cleared by reset");

  p_last_qual_r10: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid)
    else $error("last flag without a result");

endmodule

bind pair_reduce_stage pair_reduce_stage_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .hold_full (hold_full),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/test_pair_reduce_stage.sv
`timescale 1ns/1ps
module test_pair_reduce_stage;

  localparam int TW = 8;
  localparam int TL = 3;

  typedef struct {
    int          cyc;
    logic [TW:0] sum;
    logic        last;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic [TW:0]   out_sum;
  logic          out_last;

  int   n_run  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  exp_t q[$];
  bit   m_full = 0;
  logic [TW-1:0] m_hold = '0;
  logic [7:0] lfsr = 8'h5A;
  bit   done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  pair_reduce_stage #(.W(TW), .L(TL)) i_pair_reduce_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_last  (out_last)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // model of the pairing rules (R1..R6)
  task automatic model_item(input logic [TW-1:0] d, input bit l);
    exp_t e;
    e.cyc = cyc + TL;
    if (m_full) begin
      e.sum = {1'b0, m_hold} + {1'b0, d};
      e.last = l;
      q.push_back(e);
      m_full = 0;
    end else if (l) begin
      e.sum = {1'b0, d};
      e.last = 1'b1;
      q.push_back(e);
    end else begin
      m_hold = d;
      m_full = 1;
    end
  endtask

  task automatic drive(input bit v, input logic [TW-1:0] d, input bit l);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    in_last  = l;
    if (v) model_item(d, l);
  endtask

  // idle cycle with garbage on data and last (R7)
  task automatic idle();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    drive(1'b0, lfsr, lfsr[0]);
  endtask

  // result monitor: R1 R3 R4 R5 R8 R10
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_last && !out_valid) begin
        n_run++; n_fail++;
        $display("FAIL R10 out_last=%0b with out_valid=%0b expected 0", out_last, out_valid);
      end
      if (out_valid) begin
        n_run++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R10 unexpected result sum=%0d expected none", out_sum);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.cyc != cyc || e.sum != out_sum || e.last != out_last) begin
            n_fail++;
            $display("FAIL R1/R3/R4/R5/R8 cyc=%0d sum=%0d last=%0b expected cyc=%0d sum=%0d last=%0b",
                     cyc, out_sum, out_last, e.cyc, e.sum, e.last);
          end
        end
      end else if (q.size() > 0 && q[0].cyc <= cyc) begin
        n_run++; n_fail++;
        $display("FAIL R5 missing result at cyc=%0d expected sum=%0d", cyc, q[0].sum);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    done = 1;
    summary();
  end

  initial begin
    // reset state (R9)
    repeat (2) @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || out_last !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 out_valid=%0b out_last=%0b expected 0 0", out_valid, out_last);
    end
    rst = 1'b0;

    // sweep over set lengths and gap patterns; back-to-back sets test R6
    for (int gm = 0; gm < 4; gm++) begin
      for (int len = 1; len <= 9; len++) begin
        for (int i = 0; i < len; i++) begin
          logic [TW-1:0] d;
          d = (gm == 3) ? {TW{1'b1}} : TW'(len * 37 + i * 11 + gm);
          drive(1'b1, d, i == len - 1);
          if (gm == 1) idle();
          if (gm == 2) begin
            for (int k = 0; k < int'(lfsr[1:0]); k++) idle();
            idle();
          end
        end
      end
    end

    // reset while an operand is held: it must be discarded (R9)
    drive(1'b1, 8'h55, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    m_full = 0;
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 out_valid=%0b after reset expected 0", out_valid);
    end
    drive(1'b1, 8'h07, 1'b1);
    drive(1'b1, 8'h10, 1'b0);
    drive(1'b1, 8'h20, 1'b1);

    // drain and confirm nothing is outstanding (R5 R10)
    for (int k = 0; k < TL + 4; k++) drive(1'b0, '0, 1'b0);
    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R10 outstanding results=%0d expected 0", q.size());
    end
    done = 1;
    summary();
  end

endmodule